// File: doc/BRIEF.md
# Four-Layer Alpha Blending Compositor

This block lays up to four 32-bit pixel layers over a solid, fully opaque black background and emits one blended pixel per accepted input beat, in raster order. The upstream fetch logic presents one beat per output position. Every beat carries one pixel lane per layer, a valid flag and a frame-start flag. The compositor tracks the raster position itself and decides, per layer, whether the position falls inside that layer's rectangle. It then runs the pixel through a cascade of four blend stages. Each stage uses the running result as its destination and its own layer as the source.

Each layer has an enable, a premultiplied-alpha flag, a top-left placement and its own width and height. The output frame has a programmable width and height. The configuration is captured at every frame start, so a frame is always built from one consistent set of settings. The output stream carries frame-start and end-of-line markers that are aligned with the pixel data.

Top module: `layer_compositor`

## Requirements
- R1: Layer k feeds blend stage k. Stages run in the order 0,1,2,3, so an opaque layer with a higher index covers every lower layer at the same position.
- R2: Where no enabled layer covers a position, the output pixel is 0xFF000000, which is black with alpha 0xFF. Pixel bits [31:24] hold alpha, and bits [23:16], [15:8] and [7:0] hold the three colour channels. Lane k of `in_px` is bits [32k+31:32k].
- R3: For an enabled layer whose premultiplied flag is clear, each colour channel becomes D·(255−A)/255 + S·A/255. Here A is the source alpha, D is the destination channel and S is the source channel.
- R4: For an enabled layer whose premultiplied flag is set, each colour channel becomes D·(255−A)/255 + S.
- R5: The alpha result of every stage is Da·(255−A)/255 + A. Because the background is opaque, every output pixel therefore has alpha 0xFF.
- R6: A disabled layer's stage forwards the destination unchanged, whatever data arrives on its lane.
- R7: Layer k contributes only where ox ≤ x < ox+w and oy ≤ y < oy+h. The offsets ox and oy are clamped to at most width−1 and height−1 of the effective output frame.
- R8: The output width and height are clamped to the range 4 to 8190 before use. The clamped width sets where lines end, and the clamped height bounds the vertical offset.
- R9: Each accepted beat (in_valid high) produces exactly one output beat 5 clock cycles later. Idle input cycles produce idle output cycles, and reset clears the output valid flag.
- R10: out_sof is set only on the output of a beat that had in_sof. out_eol is set on the last pixel of every row, where x = width−1. x advances by one per accepted beat and wraps to 0 at the end of a row, which also increments y. in_sof resets x and y to 0.
- R11: All configuration inputs are sampled on a beat with in_sof. A change made mid-frame first takes effect with the next frame start.
- R12: Each product x·a/255 is rounded to the nearest integer. Each channel sum saturates at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_sof | input | 1 | Beat is the first pixel of a frame |
| in_px | input | 128 | Four layer pixel lanes, lane k at [32k+31:32k] |
| cfg_width | input | 13 | Output frame width |
| cfg_height | input | 13 | Output frame height |
| cfg_en | input | 4 | Per-layer enable |
| cfg_premul | input | 4 | Per-layer premultiplied-alpha flag |
| cfg_x | input | 52 | Per-layer left offset, 13 bits each |
| cfg_y | input | 52 | Per-layer top offset, 13 bits each |
| cfg_lw | input | 52 | Per-layer width, 13 bits each |
| cfg_lh | input | 52 | Per-layer height, 13 bits each |
| out_valid | output | 1 | Output pixel valid |
| out_sof | output | 1 | Output pixel starts a frame |
| out_eol | output | 1 | Output pixel ends a row |
| out_px | output | 32 | Blended output pixel |

## Verification
An input beat presented before clock edge c+1 passes through one position register and four stage registers. Its blended pixel and markers therefore appear after edge c+5. The bench stamps every driven beat with the current cycle count and computes the expected pixel and markers from its own model of the frame configuration latched at frame start. It queues these values and, when the output emerges, compares both the data and the arrival cycle, which must equal the stamp plus five. Because idle gaps are inserted at random, the queue order and the cycle stamp together show that bubbles neither shift nor drop beats.

// File: rtl/comp_pkg.sv
package comp_pkg;
  localparam int CH_W   = 8;
  localparam int NUM_CH = 4;
  localparam int PX_W   = CH_W * NUM_CH;
  localparam int LANE_W = PX_W + 2;           // {hit, premul, pixel}
  localparam int PR_W   = 2 * CH_W + 2;

  typedef logic [PX_W-1:0] px_t;
  typedef logic [CH_W-1:0] ch_t;

  localparam px_t BG_PX = {{CH_W{1'b1}}, {(PX_W-CH_W){1'b0}}};

  // x*a/255 rounded to nearest
  function automatic ch_t scale_frac(input ch_t x, input ch_t a);
    logic [PR_W-1:0] t;
    logic [PR_W-1:0] u;
    t = PR_W'(x) * PR_W'(a) + PR_W'(1 << (CH_W - 1));
    u = (t + (t >> CH_W)) >> CH_W;
    return u[CH_W-1:0];
  endfunction

  function automatic ch_t add_sat(input ch_t p, input ch_t q);
    logic [CH_W:0] s;
    s = {1'b0, p} + {1'b0, q};
    return s[CH_W] ? {CH_W{1'b1}} : s[CH_W-1:0];
  endfunction
endpackage

// File: rtl/comp_raster.sv
module comp_raster
  import comp_pkg::*;
#(
  parameter int NUM_LAYERS = 4,
  parameter int DIM_W      = 13,
  parameter int MIN_DIM    = 4,
  parameter int MAX_DIM    = 8190
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic                         in_sof,
  input  logic [NUM_LAYERS*PX_W-1:0]   in_px,
  input  logic [DIM_W-1:0]             cfg_width,
  input  logic [DIM_W-1:0]             cfg_height,
  input  logic [NUM_LAYERS-1:0]        cfg_en,
  input  logic [NUM_LAYERS-1:0]        cfg_premul,
  input  logic [NUM_LAYERS*DIM_W-1:0]  cfg_x,
  input  logic [NUM_LAYERS*DIM_W-1:0]  cfg_y,
  input  logic [NUM_LAYERS*DIM_W-1:0]  cfg_lw,
  input  logic [NUM_LAYERS*DIM_W-1:0]  cfg_lh,
  output logic                         r_valid,
  output logic                         r_sof,
  output logic                         r_eol,
  output logic [NUM_LAYERS*LANE_W-1:0] r_lane
);
  localparam int CFG_W = NUM_LAYERS * DIM_W;

  logic [DIM_W-1:0]      sh_w, sh_h;
  logic [NUM_LAYERS-1:0] sh_en, sh_pm;
  logic [CFG_W-1:0]      sh_x, sh_y, sh_lw, sh_lh;

  logic [DIM_W-1:0]      act_w, act_h;
  logic [NUM_LAYERS-1:0] act_en, act_pm;
  logic [CFG_W-1:0]      act_x, act_y, act_lw, act_lh;

  logic [DIM_W-1:0] cx, cy, bx, by, w_eff, h_eff, w_last, h_last;
  logic             row_end;
  logic [NUM_LAYERS-1:0]        hit;
  logic [NUM_LAYERS*LANE_W-1:0] lane_nx;

  function automatic logic [DIM_W-1:0] fit_dim(input logic [DIM_W-1:0] v);
    if (v < DIM_W'(MIN_DIM)) return DIM_W'(MIN_DIM);
    if (v > DIM_W'(MAX_DIM)) return DIM_W'(MAX_DIM);
    return v;
  endfunction

  // live settings on a frame-start beat, latched copy otherwise
  always_comb begin
    if (in_sof) begin
      act_w = cfg_width;  act_h = cfg_height;
      act_en = cfg_en;    act_pm = cfg_premul;
      act_x = cfg_x;      act_y = cfg_y;
      act_lw = cfg_lw;    act_lh = cfg_lh;
    end else begin
      act_w = sh_w;       act_h = sh_h;
      act_en = sh_en;     act_pm = sh_pm;
      act_x = sh_x;       act_y = sh_y;
      act_lw = sh_lw;     act_lh = sh_lh;
    end
  end

  assign w_eff   = fit_dim(act_w);
  assign h_eff   = fit_dim(act_h);
  assign w_last  = w_eff - 1'b1;
  assign h_last  = h_eff - 1'b1;
  assign bx      = in_sof ? '0 : cx;
  assign by      = in_sof ? '0 : cy;
  assign row_end = (bx == w_last);

  for (genvar k = 0; k < NUM_LAYERS; k++) begin : g_layer
    logic [DIM_W-1:0] lx, ly, ox, oy;
    logic [DIM_W:0]   xe, ye;
    assign lx = act_x[k*DIM_W +: DIM_W];
    assign ly = act_y[k*DIM_W +: DIM_W];
    assign ox = (lx > w_last) ? w_last : lx;
    assign oy = (ly > h_last) ? h_last : ly;
    assign xe = {1'b0, ox} + {1'b0, act_lw[k*DIM_W +: DIM_W]};
    assign ye = {1'b0, oy} + {1'b0, act_lh[k*DIM_W +: DIM_W]};
    assign hit[k] = act_en[k] && (bx >= ox) && ({1'b0, bx} < xe) &&
                    (by >= oy) && ({1'b0, by} < ye);
    assign lane_nx[k*LANE_W +: LANE_W] = {hit[k], act_pm[k], in_px[k*PX_W +: PX_W]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_valid <= 1'b0;
      r_sof   <= 1'b0;
      r_eol   <= 1'b0;
      r_lane  <= '0;
      cx      <= '0;
      cy      <= '0;
      sh_w    <= '0;
      sh_h    <= '0;
      sh_en   <= '0;
      sh_pm   <= '0;
      sh_x    <= '0;
      sh_y    <= '0;
      sh_lw   <= '0;
      sh_lh   <= '0;
    end else begin
      r_valid <= in_valid;
      r_sof   <= in_valid && in_sof;
      r_eol   <= in_valid && row_end;
      r_lane  <= lane_nx;
      if (in_valid) begin
        if (row_end) begin
          cx <= '0;
          cy <= by + 1'b1;
        end else begin
          cx <= bx + 1'b1;
          cy <= by;
        end
        if (in_sof) begin
          sh_w  <= cfg_width;
          sh_h  <= cfg_height;
          sh_en <= cfg_en;
          sh_pm <= cfg_premul;
          sh_x  <= cfg_x;
          sh_y  <= cfg_y;
          sh_lw <= cfg_lw;
          sh_lh <= cfg_lh;
        end
      end
    end
  end
endmodule

// File: rtl/comp_delay.sv
module comp_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[DEPTH-1];
endmodule

// File: rtl/comp_blend_stage.sv
module comp_blend_stage
  import comp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic i_valid,
  input  logic i_sof,
  input  logic i_eol,
  input  px_t  i_dst,
  input  logic i_use,
  input  logic i_pm,
  input  px_t  i_src,
  output logic o_valid,
  output logic o_sof,
  output logic o_eol,
  output px_t  o_dst
);
  ch_t a, na, dterm, sterm;
  px_t mix;

  always_comb begin
    a   = i_src[PX_W-1 -: CH_W];
    na  = {CH_W{1'b1}} - a;
    mix = '0;
    for (int c = 0; c < NUM_CH - 1; c++) begin
      dterm = scale_frac(i_dst[c*CH_W +: CH_W], na);
      sterm = i_pm ? i_src[c*CH_W +: CH_W] : scale_frac(i_src[c*CH_W +: CH_W], a);
      mix[c*CH_W +: CH_W] = add_sat(dterm, sterm);
    end
    mix[PX_W-1 -: CH_W] = add_sat(scale_frac(i_dst[PX_W-1 -: CH_W], na), a);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_sof   <= 1'b0;
      o_eol   <= 1'b0;
      o_dst   <= '0;
    end else begin
      o_valid <= i_valid;
      o_sof   <= i_sof;
      o_eol   <= i_eol;
      o_dst   <= i_use ? mix : i_dst;
    end
  end
endmodule

// File: rtl/layer_compositor.sv
module layer_compositor
  import comp_pkg::*;
#(
  parameter int NUM_LAYERS = 4,
  parameter int DIM_W      = 13,
  parameter int MIN_DIM    = 4,
  parameter int MAX_DIM    = 8190
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic                        in_sof,
  input  logic [NUM_LAYERS*32-1:0]    in_px,
  input  logic [DIM_W-1:0]            cfg_width,
  input  logic [DIM_W-1:0]            cfg_height,
  input  logic [NUM_LAYERS-1:0]       cfg_en,
  input  logic [NUM_LAYERS-1:0]       cfg_premul,
  input  logic [NUM_LAYERS*DIM_W-1:0] cfg_x,
  input  logic [NUM_LAYERS*DIM_W-1:0] cfg_y,
  input  logic [NUM_LAYERS*DIM_W-1:0] cfg_lw,
  input  logic [NUM_LAYERS*DIM_W-1:0] cfg_lh,
  output logic                        out_valid,
  output logic                        out_sof,
  output logic                        out_eol,
  output logic [31:0]                 out_px
);
  logic                         r_valid, r_sof, r_eol;
  logic [NUM_LAYERS*LANE_W-1:0] r_lane;
  logic [NUM_LAYERS:0]          v_ch, s_ch, e_ch;
  px_t                          d_ch [NUM_LAYERS+1];

  comp_raster #(
    .NUM_LAYERS(NUM_LAYERS), .DIM_W(DIM_W), .MIN_DIM(MIN_DIM), .MAX_DIM(MAX_DIM)
  ) u_raster (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_px(in_px),
    .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_en(cfg_en),
    .cfg_premul(cfg_premul), .cfg_x(cfg_x), .cfg_y(cfg_y), .cfg_lw(cfg_lw),
    .cfg_lh(cfg_lh), .r_valid(r_valid), .r_sof(r_sof), .r_eol(r_eol), .r_lane(r_lane)
  );

  assign v_ch[0] = r_valid;
  assign s_ch[0] = r_sof;
  assign e_ch[0] = r_eol;
  assign d_ch[0] = BG_PX;

  for (genvar k = 0; k < NUM_LAYERS; k++) begin : g_stage
    logic [LANE_W-1:0] lane_d;
    if (k == 0) begin : g_direct
      assign lane_d = r_lane[0 +: LANE_W];
    end else begin : g_delayed
      comp_delay #(.W(LANE_W), .DEPTH(k)) u_dly (
        .clk(clk), .rst(rst), .d(r_lane[k*LANE_W +: LANE_W]), .q(lane_d)
      );
    end

    comp_blend_stage u_blend (
      .clk(clk), .rst(rst),
      .i_valid(v_ch[k]), .i_sof(s_ch[k]), .i_eol(e_ch[k]), .i_dst(d_ch[k]),
      .i_use(lane_d[LANE_W-1]), .i_pm(lane_d[LANE_W-2]), .i_src(lane_d[PX_W-1:0]),
      .o_valid(v_ch[k+1]), .o_sof(s_ch[k+1]), .o_eol(e_ch[k+1]), .o_dst(d_ch[k+1])
    );
  end

  assign out_valid = v_ch[NUM_LAYERS];
  assign out_sof   = s_ch[NUM_LAYERS];
  assign out_eol   = e_ch[NUM_LAYERS];
  assign out_px    = d_ch[NUM_LAYERS];
endmodule

// File: rtl/comp_chk.sv
module comp_chk #(
  parameter int LAT = 5
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        out_valid,
  input logic        out_sof,
  input logic        out_eol,
  input logic [31:0] out_px
);
  logic [LAT-1:0] vsr;

  always_ff @(posedge clk) begin
    if (rst) vsr <= '0;
    else     vsr <= {vsr[LAT-2:0], in_valid};
  end

  // R9
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == vsr[LAT-1]);

  // R10
  sof_has_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid);

  // R10
  eol_has_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_eol |-> out_valid);

  // R8
  sof_not_eol_chk: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> !out_eol);

  // R5
  alpha_opaque_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_px[31:24] == 8'hFF));
endmodule

bind layer_compositor comp_chk #(.LAT(NUM_LAYERS + 1)) u_comp_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .out_sof(out_sof), .out_eol(out_eol), .out_px(out_px)
);

// File: tb/layer_compositor_bench.sv
module layer_compositor_bench;
  localparam int NL  = 4;
  localparam int DW  = 13;
  localparam int LAT = NL + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic              in_valid = 1'b0, in_sof = 1'b0;
  logic [NL*32-1:0]  in_px = '0;
  logic [DW-1:0]     cfg_width = '0, cfg_height = '0;
  logic [NL-1:0]     cfg_en = '0, cfg_premul = '0;
  logic [NL*DW-1:0]  cfg_x = '0, cfg_y = '0, cfg_lw = '0, cfg_lh = '0;
  logic              out_valid, out_sof, out_eol;
  logic [31:0]       out_px;

  layer_compositor u_layer_compositor (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_px(in_px),
    .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_en(cfg_en),
    .cfg_premul(cfg_premul), .cfg_x(cfg_x), .cfg_y(cfg_y), .cfg_lw(cfg_lw),
    .cfg_lh(cfg_lh), .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol),
    .out_px(out_px)
  );

  int     checks = 0, failures = 0;
  longint cyc = 0;
  bit     done = 0;
  always @(posedge clk) cyc++;

  // model of the frame configuration
  int m_w, m_h;
  int m_x[NL], m_y[NL], m_lw[NL], m_lh[NL];
  bit m_en[NL], m_pm[NL];

  logic [31:0] q_px[$];
  bit          q_sof[$], q_eol[$];
  longint      q_cyc[$];
  string       q_tag[$];

  string       cur_tag = "R2";
  bit          use_fix = 0;
  logic [31:0] fix_px[NL];

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int mulr(int x, int a);
    return (2 * x * a + 255) / 510;
  endfunction

  task automatic latch_cfg();
    int w, h;
    w = cfg_width;  if (w < 4) w = 4;  if (w > 8190) w = 8190;
    h = cfg_height; if (h < 4) h = 4;  if (h > 8190) h = 8190;
    m_w = w; m_h = h;
    for (int k = 0; k < NL; k++) begin
      m_en[k] = cfg_en[k];
      m_pm[k] = cfg_premul[k];
      m_x[k]  = cfg_x[k*DW +: DW]; if (m_x[k] > w - 1) m_x[k] = w - 1;
      m_y[k]  = cfg_y[k*DW +: DW]; if (m_y[k] > h - 1) m_y[k] = h - 1;
      m_lw[k] = cfg_lw[k*DW +: DW];
      m_lh[k] = cfg_lh[k*DW +: DW];
    end
  endtask

  function automatic logic [31:0] ref_px(int x, int y, logic [NL*32-1:0] lanes);
    logic [31:0] d, s, nd;
    int a, v;
    d = 32'hFF000000;
    for (int k = 0; k < NL; k++) begin
      if (m_en[k] && x >= m_x[k] && x < m_x[k] + m_lw[k] &&
          y >= m_y[k] && y < m_y[k] + m_lh[k]) begin
        s = lanes[k*32 +: 32];
        a = s[31:24];
        for (int c = 0; c < 3; c++) begin
          v = mulr(d[c*8 +: 8], 255 - a) + (m_pm[k] ? int'(s[c*8 +: 8]) : mulr(s[c*8 +: 8], a));
          if (v > 255) v = 255;
          nd[c*8 +: 8] = v[7:0];
        end
        v = mulr(d[31:24], 255 - a) + a;
        if (v > 255) v = 255;
        nd[31:24] = v[7:0];
        d = nd;
      end
    end
    return d;
  endfunction

  task automatic beat(bit sof, int x, int y);
    in_valid = 1'b1;
    in_sof   = sof;
    for (int k = 0; k < NL; k++)
      in_px[k*32 +: 32] = use_fix ? fix_px[k] : $urandom();
    if (sof) latch_cfg();
    q_px.push_back(ref_px(x, y, in_px));
    q_sof.push_back(sof);
    q_eol.push_back(x == m_w - 1);
    q_cyc.push_back(cyc);
    q_tag.push_back(cur_tag);
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
  endtask

  task automatic run_frame(int rows, int gap_pct, int chg_at);
    int n = 0;
    latch_cfg();
    for (int y = 0; y < rows; y++) begin
      for (int x = 0; x < m_w; x++) begin
        while (gap_pct > 0 && $urandom_range(99) < gap_pct) @(negedge clk);
        if (n == chg_at) begin
          // R11: changed mid-frame, must not affect this frame
          cfg_en     = ~cfg_en;
          cfg_premul = ~cfg_premul;
          cfg_x      = {NL{13'd0}};
          cfg_lw     = {NL{13'd1}};
          cfg_width  = 13'd9;
        end
        beat(x == 0 && y == 0, x, y);
        n++;
      end
    end
  endtask

  task automatic set_layer(int k, int x, int y, int w, int h);
    cfg_x[k*DW +: DW]  = x[DW-1:0];
    cfg_y[k*DW +: DW]  = y[DW-1:0];
    cfg_lw[k*DW +: DW] = w[DW-1:0];
    cfg_lh[k*DW +: DW] = h[DW-1:0];
  endtask

  // output monitor
  always @(negedge clk) begin
    if (!rst && !done && out_valid) begin
      if (q_px.size() == 0) begin
        chk("R9 unexpected output beat", 1, 0);
      end else begin
        string t;
        t = q_tag.pop_front();
        chk(t, out_px, q_px.pop_front());
        chk("R10 sof marker", out_sof, q_sof.pop_front());
        chk("R10 eol marker", out_eol, q_eol.pop_front());
        chk("R9 latency", cyc, q_cyc.pop_front() + LAT);
        chk("R5 opaque alpha", out_px[31:24], 8'hFF);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk("R9 reset valid low", out_valid, 0);
    chk("R10 reset sof low", out_sof, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 idle after reset", out_valid, 0);

    // R2: nothing enabled
    cur_tag = "R2 background"; cfg_width = 13'd5; cfg_height = 13'd4; cfg_en = '0;
    run_frame(2, 0, -1);

    // R3: straight alpha on layer 0
    use_fix = 1;
    fix_px[0] = 32'h80FF4001; fix_px[1] = 32'hFF123456; fix_px[2] = 32'h00FFFFFF; fix_px[3] = 32'h7F7F7F7F;
    cur_tag = "R3 straight blend"; cfg_width = 13'd6; cfg_en = 4'b0001; cfg_premul = 4'b0000;
    for (int k = 0; k < NL; k++) set_layer(k, 0, 0, 8191, 8191);
    run_frame(2, 0, -1);

    // R4 / R12: premultiplied over opaque white, with saturation
    fix_px[0] = 32'hFFFFFFFF; fix_px[1] = 32'h40FF2000;
    cur_tag = "R4 R12 premul and saturation"; cfg_en = 4'b0011; cfg_premul = 4'b0010;
    run_frame(1, 0, -1);

    // R1 / R6: layer 3 covers layer 0, middle layers disabled
    fix_px[0] = 32'hFF112233; fix_px[1] = 32'hFF0000FF; fix_px[2] = 32'hFF00FF00; fix_px[3] = 32'hFFAABBCC;
    cur_tag = "R1 R6 order and disabled"; cfg_en = 4'b1001; cfg_premul = 4'b0000;
    set_layer(3, 2, 0, 2, 8191);
    run_frame(2, 0, -1);
    use_fix = 0;

    // R7: placement rectangle, then clamped offsets
    cur_tag = "R7 placement"; cfg_width = 13'd8; cfg_height = 13'd4; cfg_en = 4'b0100;
    set_layer(2, 2, 1, 3, 2);
    run_frame(4, 0, -1);
    cur_tag = "R7 clamped offset"; set_layer(2, 50, 50, 5, 5);
    run_frame(4, 0, -1);

    // R8: width/height clamps
    cur_tag = "R8 min width"; cfg_width = 13'd1; cfg_height = 13'd2; cfg_en = 4'b0001;
    set_layer(0, 0, 9, 4, 1);
    run_frame(4, 0, -1);
    cur_tag = "R8 max width"; cfg_width = 13'd8191; cfg_height = 13'd4;
    set_layer(0, 8191, 0, 1, 1);
    run_frame(1, 0, -1);

    // R11: mid-frame configuration change
    cur_tag = "R11 frame-start sampling"; cfg_width = 13'd6; cfg_height = 13'd4;
    cfg_en = 4'b1111; cfg_premul = 4'b0101;
    for (int k = 0; k < NL; k++) set_layer(k, k, k % 2, 3, 2);
    run_frame(2, 0, 5);
    cur_tag = "R11 next frame uses change";
    run_frame(2, 0, -1);

    // random frames with idle gaps
    cur_tag = "R3 R4 R6 R7 R9 random";
    for (int f = 0; f < 12; f++) begin
      cfg_width  = 13'($urandom_range(4, 10));
      cfg_height = 13'($urandom_range(4, 6));
      cfg_en     = 4'($urandom());
      cfg_premul = 4'($urandom());
      for (int k = 0; k < NL; k++)
        set_layer(k, $urandom_range(0, 12), $urandom_range(0, 7),
                  $urandom_range(0, 10), $urandom_range(0, 6));
      run_frame(int'(cfg_height), 25, -1);
    end

    repeat (LAT + 3) @(negedge clk);
    chk("R9 all beats emerged", q_px.size(), 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule